// File: doc/BRIEF.md
# Linked command list executor

This block runs a chain of command descriptors held in memory. Each descriptor starts at a byte address. It holds a 16-bit status half-word, a 16-bit command half-word, a 32-bit pointer to the next descriptor and, for some commands, a parameter area. The block reaches memory through a single 16-bit request/valid port with one access outstanding at a time.

For each descriptor the block first marks it busy. It then reads the command and acts on the 3-bit opcode. Three opcodes are handled inside the block: no-op, configure (which copies a bounded run of bytes into an internal configuration array) and link test (which writes the current link state back into the descriptor). Every other opcode is passed to an external handler as a one-cycle dispatch strobe. The block then writes a completion status, fetches the next pointer and applies the descriptor's flags to decide whether to continue, stop or suspend.

A host starts a walk by pulsing `start` with the address of the first descriptor. It watches `cu_state`, `irq` and `done_flag` to learn how the walk went.

Top module: `cmdx_exec`

## Requirements
- R1: After reset `cu_state` is 0 (idle), `mem_req`, `irq`, `disp_valid` and `done_flag` are low, and every configuration byte is 0x00.
- R2: For each descriptor at address P the accesses run in this order: write 0x4000 to P, read P+2, then the opcode's own work, then write 0xA000 to P, read P+4 (low half of the next pointer) and read P+6 (high half).
- R3: A request holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until the cycle in which `mem_valid` completes it, and no second access is issued before then.
- R4: Opcodes 1, 3, 4, 6 and 7 (bits 2:0 of the command half-word) make no memory access of their own. They raise `disp_valid` for exactly one cycle, carrying the opcode on `disp_op` and P on `disp_ptr`, and the completion write follows in the next cycle.
- R5: Opcode 5 (link test) writes 0x8000 (or 0x0000 when `link_up` is low) to P+8 and then 0x0000 to P+10.
- R6: Opcode 2 (configure) takes a count N from bits 3:0 of the byte at P+8 (the low byte of the half-word at P+8), raised to at least 4 and limited to CFG_BYTES. Configuration byte k (k < N) receives memory byte P+8+k, with even bytes in the low half and odd bytes in the high half of each half-word. The read half-words are P+8, P+10, … up to P+8+N-1. Bytes at index N and above keep their values.
- R7: When a configure finishes, configuration byte 10 is raised to 5 if it is smaller, and byte 13 has bits 5:0 set.
- R8: After the next pointer is read, the walk ends with `cu_state` = 0 when the pointer is 0x00000000 or 0xFFFFFFFF, or when command bit 15 (end of list) is set. Both pointer reads still take place in that case.
- R9: Command bit 14 (suspend) ends the walk with `cu_state` = 1. Suspend takes precedence over end of list and over a null pointer.
- R10: When a command completes with bit 13 set, `done_flag` becomes 1 and `irq` pulses for one cycle. When it completes with bit 13 clear, `done_flag` becomes 0 and there is no pulse.
- R11: `start` is taken only while `cu_state` is not 2 (active). A null start pointer sets `cu_state` to 0 without any memory access, a valid one sets it to 2, and a pulse during a walk changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk at `start_ptr` |
| start_ptr | input | 32 | Address of the first descriptor |
| link_up | input | 1 | Current link state reported by link test |
| mem_req | output | 1 | Memory access requested |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the half-word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_valid` |
| mem_valid | input | 1 | Completes the current access |
| disp_valid | output | 1 | One-cycle strobe for an externally handled opcode |
| disp_op | output | 3 | Opcode being dispatched |
| disp_ptr | output | 32 | Descriptor address being dispatched |
| irq | output | 1 | One-cycle interrupt request |
| done_flag | output | 1 | Command-done event flag |
| cu_state | output | 2 | 0 idle, 1 suspended, 2 active |
| cfg_bytes | output | 8*CFG_BYTES | Configuration array, byte k at bits 8k+7:8k |

## Verification
The hard cases sit at the boundaries of the configure copy: an odd clamped count, where the high half of the last half-word read must be dropped, and a raw count above the array size. A later walk follows an earlier one without a reset, so leftover bytes and the fix-ups can be told apart. The bench reaches these by building descriptor chains in its memory model with chosen count nibbles. It also combines flags on one descriptor (suspend together with end of list, suspend together with a null link), and it pulses start again mid-walk while memory latency varies between runs.

// File: rtl/cmdx_pkg.sv
package cmdx_pkg;

  localparam int PTR_W = 32;

  typedef enum logic [1:0] {
    CU_IDLE   = 2'd0,
    CU_SUSP   = 2'd1,
    CU_ACTIVE = 2'd2
  } cu_state_e;

  localparam logic [15:0] ST_BUSY = 16'h4000;
  localparam logic [15:0] ST_DONE = 16'hA000;
  localparam logic [15:0] LINK_ON = 16'h8000;

  localparam logic [2:0] OP_NOP  = 3'd0;
  localparam logic [2:0] OP_CFG  = 3'd2;
  localparam logic [2:0] OP_LINK = 3'd5;

  localparam int MINLEN_IDX = 10;
  localparam int ONES_IDX   = 13;

  function automatic logic ptr_is_null(input logic [PTR_W-1:0] p);
    return (p == '0) || (&p);
  endfunction

  function automatic int cfg_count(input logic [3:0] nib, input int cap);
    int n;
    n = int'(nib);
    if (n < 4) n = 4;
    if (n > cap) n = cap;
    return n;
  endfunction

  function automatic logic [7:0] fix_byte(input int idx, input logic [7:0] b);
    if (idx == MINLEN_IDX) return (b < 8'd5) ? 8'd5 : b;
    if (idx == ONES_IDX) return b | 8'h3F;
    return b;
  endfunction

endpackage

// File: rtl/cmdx_cfg_store.sv
module cmdx_cfg_store
  import cmdx_pkg::*;
#(
  parameter int CFG_BYTES = 14,
  parameter int CNT_W     = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_lo,
  input  logic                   wr_hi,
  input  logic [CNT_W-1:0]       wr_idx,
  input  logic [15:0]            wr_data,
  input  logic                   fix,
  output logic [CFG_BYTES*8-1:0] cfg_flat
);

  for (genvar g = 0; g < CFG_BYTES; g++) begin : g_byte
    logic [7:0] b_q;
    always_ff @(posedge clk) begin
      if (!rst_n) b_q <= '0;
      else if (wr_lo && wr_idx == CNT_W'(g)) b_q <= wr_data[7:0];
      else if (wr_hi && (wr_idx + CNT_W'(1)) == CNT_W'(g)) b_q <= wr_data[15:8];
      else if (fix) b_q <= fix_byte(g, b_q);
    end
    assign cfg_flat[g*8 +: 8] = b_q;
  end

  // R7
  cfg_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fix |=> (cfg_flat[MINLEN_IDX*8 +: 8] >= 8'd5) && (cfg_flat[ONES_IDX*8 +: 6] == 6'h3F));

endmodule

// File: rtl/cmdx_seq.sv
module cmdx_seq
  import cmdx_pkg::*;
#(
  parameter int CFG_BYTES = 14,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PTR_W-1:0] start_ptr,
  input  logic             link_up,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PTR_W-1:0] mem_addr,
  output logic [15:0]      mem_wdata,
  input  logic [15:0]      mem_rdata,
  input  logic             mem_valid,
  output logic             cfg_wr_lo,
  output logic             cfg_wr_hi,
  output logic [CNT_W-1:0] cfg_idx,
  output logic [15:0]      cfg_wdata,
  output logic             cfg_fix,
  output logic             disp_valid,
  output logic [2:0]       disp_op,
  output logic [PTR_W-1:0] disp_ptr,
  output logic             irq,
  output logic             done_flag,
  output logic [1:0]       cu_state
);

  typedef enum logic [3:0] {
    S_IDLE, S_MARK, S_FETCH, S_CFG, S_FIX, S_LNK_LO, S_LNK_HI,
    S_DISP, S_CLOSE, S_NEXT_LO, S_NEXT_HI
  } step_e;

  step_e            step_q;
  cu_state_e        cu_q;
  logic [PTR_W-1:0] ptr_q;
  logic [2:0]       op_q;
  logic [2:0]       flg_q;      // {end of list, suspend, interrupt}
  logic             lnk_q;
  logic [CNT_W-1:0] k_q, n_q;
  logic [15:0]      nxt_lo_q;
  logic             done_q, irq_q;

  logic             acc_done;
  logic [CNT_W-1:0] n_now, k_next;
  logic [PTR_W-1:0] nxt_ptr;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr_q;
    mem_wdata = '0;
    unique case (step_q)
      S_MARK:    begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = ST_BUSY; end
      S_FETCH:   begin mem_req = 1'b1; mem_addr = ptr_q + 32'd2; end
      S_CFG:     begin mem_req = 1'b1; mem_addr = ptr_q + 32'd8 + PTR_W'(k_q); end
      S_LNK_LO:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = ptr_q + 32'd8;
                       mem_wdata = lnk_q ? LINK_ON : 16'h0000; end
      S_LNK_HI:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = ptr_q + 32'd10; end
      S_CLOSE:   begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = ST_DONE; end
      S_NEXT_LO: begin mem_req = 1'b1; mem_addr = ptr_q + 32'd4; end
      S_NEXT_HI: begin mem_req = 1'b1; mem_addr = ptr_q + 32'd6; end
      default:   ;
    endcase
  end

  assign acc_done  = mem_req && mem_valid;
  assign n_now     = (k_q == '0) ? CNT_W'(cfg_count(mem_rdata[3:0], CFG_BYTES)) : n_q;
  assign k_next    = k_q + CNT_W'(2);
  assign nxt_ptr   = {mem_rdata, nxt_lo_q};

  assign cfg_wr_lo = (step_q == S_CFG) && acc_done;
  assign cfg_wr_hi = cfg_wr_lo && ((k_q + CNT_W'(1)) < n_now);
  assign cfg_idx   = k_q;
  assign cfg_wdata = mem_rdata;
  assign cfg_fix   = (step_q == S_FIX);

  assign disp_valid = (step_q == S_DISP);
  assign disp_op    = op_q;
  assign disp_ptr   = ptr_q;
  assign irq        = irq_q;
  assign done_flag  = done_q;
  assign cu_state   = cu_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q   <= S_IDLE;
      cu_q     <= CU_IDLE;
      ptr_q    <= '0;
      op_q     <= '0;
      flg_q    <= '0;
      lnk_q    <= 1'b0;
      k_q      <= '0;
      n_q      <= '0;
      nxt_lo_q <= '0;
      done_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (step_q)
        S_IDLE: if (start) begin
          if (ptr_is_null(start_ptr)) cu_q <= CU_IDLE;
          else begin
            ptr_q  <= start_ptr;
            cu_q   <= CU_ACTIVE;
            step_q <= S_MARK;
          end
        end
        S_MARK:   if (acc_done) step_q <= S_FETCH;
        S_FETCH:  if (acc_done) begin
          op_q  <= mem_rdata[2:0];
          flg_q <= mem_rdata[15:13];
          lnk_q <= link_up;
          k_q   <= '0;
          case (mem_rdata[2:0])
            OP_NOP:  step_q <= S_CLOSE;
            OP_CFG:  step_q <= S_CFG;
            OP_LINK: step_q <= S_LNK_LO;
            default: step_q <= S_DISP;
          endcase
        end
        S_CFG: if (acc_done) begin
          n_q <= n_now;
          k_q <= k_next;
          if (k_next >= n_now) step_q <= S_FIX;
        end
        S_FIX:     step_q <= S_CLOSE;
        S_LNK_LO:  if (acc_done) step_q <= S_LNK_HI;
        S_LNK_HI:  if (acc_done) step_q <= S_CLOSE;
        S_DISP:    step_q <= S_CLOSE;
        S_CLOSE:   if (acc_done) step_q <= S_NEXT_LO;
        S_NEXT_LO: if (acc_done) begin
          nxt_lo_q <= mem_rdata;
          step_q   <= S_NEXT_HI;
        end
        S_NEXT_HI: if (acc_done) begin
          done_q <= flg_q[0];
          irq_q  <= flg_q[0];
          if (flg_q[1]) begin
            cu_q   <= CU_SUSP;
            step_q <= S_IDLE;
          end else if (flg_q[2] || ptr_is_null(nxt_ptr)) begin
            cu_q   <= CU_IDLE;
            step_q <= S_IDLE;
          end else begin
            ptr_q  <= nxt_ptr;
            step_q <= S_MARK;
          end
        end
        default: step_q <= S_IDLE;
      endcase
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R11
  req_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (cu_state == CU_ACTIVE));

  // R10
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R4
  disp_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> !disp_valid && mem_req && mem_we && (mem_wdata == ST_DONE));

endmodule

// File: rtl/cmdx_exec.sv
module cmdx_exec
  import cmdx_pkg::*;
#(
  parameter int CFG_BYTES = 14
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [31:0]            start_ptr,
  input  logic                   link_up,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [31:0]            mem_addr,
  output logic [15:0]            mem_wdata,
  input  logic [15:0]            mem_rdata,
  input  logic                   mem_valid,
  output logic                   disp_valid,
  output logic [2:0]             disp_op,
  output logic [31:0]            disp_ptr,
  output logic                   irq,
  output logic                   done_flag,
  output logic [1:0]             cu_state,
  output logic [CFG_BYTES*8-1:0] cfg_bytes
);

  localparam int CNT_W = $clog2(CFG_BYTES + 2) + 1;

  logic             cfg_wr_lo, cfg_wr_hi, cfg_fix;
  logic [CNT_W-1:0] cfg_idx;
  logic [15:0]      cfg_wdata;

  cmdx_seq #(.CFG_BYTES(CFG_BYTES), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr), .link_up(link_up),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_valid(mem_valid),
    .cfg_wr_lo(cfg_wr_lo), .cfg_wr_hi(cfg_wr_hi), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_fix(cfg_fix),
    .disp_valid(disp_valid), .disp_op(disp_op), .disp_ptr(disp_ptr),
    .irq(irq), .done_flag(done_flag), .cu_state(cu_state)
  );

  cmdx_cfg_store #(.CFG_BYTES(CFG_BYTES), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_lo(cfg_wr_lo), .wr_hi(cfg_wr_hi), .wr_idx(cfg_idx),
    .wr_data(cfg_wdata), .fix(cfg_fix), .cfg_flat(cfg_bytes)
  );

  // R11
  active_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (cu_state == 2'd2));

endmodule

// File: tb/cmdx_exec_test.sv
module cmdx_exec_test;

  localparam int NB = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start = 1'b0;
  logic [31:0] start_ptr = '0;
  logic        link_up = 1'b1;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_valid = 1'b0;
  logic        disp_valid;
  logic [2:0]  disp_op;
  logic [31:0] disp_ptr;
  logic        irq, done_flag;
  logic [1:0]  cu_state;
  logic [NB*8-1:0] cfg_bytes;

  cmdx_exec #(.CFG_BYTES(NB)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr), .link_up(link_up),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_valid(mem_valid),
    .disp_valid(disp_valid), .disp_op(disp_op), .disp_ptr(disp_ptr),
    .irq(irq), .done_flag(done_flag), .cu_state(cu_state), .cfg_bytes(cfg_bytes)
  );

  typedef struct {
    int          kind;   // 0 read, 1 write, 2 dispatch
    int unsigned addr;
    int unsigned data;
  } ev_t;

  logic [15:0] mem [0:4095];
  ev_t         expq[$];
  int          checks = 0, errors = 0;
  int          lat = 0, wait_cnt = 0, irq_seen = 0;
  int          ecfg [NB];
  int          exp_cu = 0, exp_irqs = 0, exp_done = 0;

  task automatic check(input string req, input bit ok, input string what,
                       input int unsigned act, input int unsigned expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic expect_ev(input int kind, input int unsigned addr, input int unsigned data,
                           input string req);
    ev_t e;
    if (expq.size() == 0) begin
      check(req, 1'b0, "unexpected event kind", kind, 99);
      return;
    end
    e = expq.pop_front();
    check(req, e.kind == kind, "event kind", kind, e.kind);
    check(req, e.addr == addr, "event address", addr, e.addr);
    if (kind != 0) check(req, e.data == data, "event data", data, e.data);
  endtask

  // memory model and event monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) irq_seen++;
      if (disp_valid) expect_ev(2, disp_ptr, disp_op, "R4");
      if (mem_valid) begin
        mem_valid = 1'b0;
        wait_cnt  = 0;
      end else if (mem_req) begin
        if (wait_cnt >= lat) begin
          if (mem_we) begin
            expect_ev(1, mem_addr, mem_wdata, "R2/R3");
            mem[mem_addr[12:1]] = mem_wdata;
          end else begin
            expect_ev(0, mem_addr, 0, "R2/R3");
            mem_rdata = mem[mem_addr[12:1]];
          end
          mem_valid = 1'b1;
        end else wait_cnt++;
      end
    end
  end

  function automatic int unsigned rd16(input int unsigned a);
    return int'(mem[a[12:1]]);
  endfunction

  task automatic push(input int kind, input int unsigned addr, input int unsigned data);
    ev_t e;
    e.kind = kind; e.addr = addr; e.data = data;
    expq.push_back(e);
  endtask

  task automatic put_desc(input int unsigned p, input int unsigned cmd, input int unsigned link);
    mem[p[12:1] + 1] = cmd[15:0];
    mem[p[12:1] + 2] = link[15:0];
    mem[p[12:1] + 3] = link[31:16];
  endtask

  task automatic set_byte(input int unsigned a, input logic [7:0] b);
    if (a % 2 == 0) mem[a[12:1]][7:0] = b;
    else mem[a[12:1]][15:8] = b;
  endtask

  // behavioural walk of the list, done before the design touches memory
  task automatic predict(input int unsigned p0);
    int unsigned p, cmd, nxt;
    int n;
    p = p0;
    if (p == 0 || p == 32'hFFFF_FFFF) begin
      exp_cu = 0;
      return;
    end
    forever begin
      push(1, p, 16'h4000);
      cmd = rd16(p + 2);
      push(0, p + 2, 0);
      case (cmd % 8)
        0: ;
        2: begin
          n = rd16(p + 8) % 16;
          if (n < 4) n = 4;
          if (n > NB) n = NB;
          for (int b = 0; b < n; b++) begin
            int unsigned hw;
            hw = rd16(p + 8 + (b / 2) * 2);
            if (b % 2 == 0) push(0, p + 8 + b, 0);
            ecfg[b] = (b % 2 == 0) ? (hw % 256) : (hw / 256);
          end
          if (ecfg[10] < 5) ecfg[10] = 5;
          ecfg[13] = ecfg[13] | 'h3F;
        end
        5: begin
          push(1, p + 8, link_up ? 'h8000 : 0);
          push(1, p + 10, 0);
        end
        default: push(2, p, cmd % 8);
      endcase
      push(1, p, 16'hA000);
      push(0, p + 4, 0);
      push(0, p + 6, 0);
      nxt = rd16(p + 4) + rd16(p + 6) * 65536;
      if ((cmd / 8192) % 2 == 1) begin exp_irqs++; exp_done = 1; end
      else exp_done = 0;
      if ((cmd / 16384) % 2 == 1) begin exp_cu = 1; break; end
      if (cmd / 32768 == 1 || nxt == 0 || nxt == 32'hFFFF_FFFF) begin exp_cu = 0; break; end
      p = nxt;
    end
  endtask

  task automatic run(input string req, input int unsigned p, input bit poke);
    exp_irqs = 0;
    predict(p);
    irq_seen = 0;
    @(negedge clk); start = 1'b1; start_ptr = p;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      check("R11", cu_state == 2, "walk active at poke", cu_state, 2);
      start = 1'b1; start_ptr = 32'h100;
      @(negedge clk); start = 1'b0;
    end
    for (int i = 0; i < 4000 && cu_state == 2; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(req, expq.size() == 0, "events left over", expq.size(), 0);
    expq.delete();
    check(req, cu_state == exp_cu[1:0], "cu_state", cu_state, exp_cu);
    check("R10", done_flag == exp_done[0], "done_flag", done_flag, exp_done);
    check("R10", irq_seen == exp_irqs, "irq pulses", irq_seen, exp_irqs);
    for (int b = 0; b < NB; b++)
      check("R6/R7", cfg_bytes[b*8 +: 8] == ecfg[b][7:0], $sformatf("cfg byte %0d", b),
            cfg_bytes[b*8 +: 8], ecfg[b]);
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    report();
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    for (int b = 0; b < NB; b++) ecfg[b] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", cu_state == 0, "cu_state", cu_state, 0);
    check("R1", !mem_req && !irq && !disp_valid && !done_flag, "outputs idle",
          {mem_req, irq, disp_valid, done_flag}, 0);
    check("R1", cfg_bytes == '0, "cfg zero", cfg_bytes[31:0], 0);

    // R2 R5 R10: nop with interrupt, link test, nop ending on zero link
    put_desc(32'h100, 'h2000, 32'h140);
    put_desc(32'h140, 'h0005, 32'h180);
    put_desc(32'h180, 'h0000, 32'h0);
    lat = 0;
    run("R2", 32'h100, 1'b0);

    // R6 R7 R8: clamp up to 4, then raw 15 clamped to NB with end of list
    put_desc(32'h200, 'h0002, 32'h240);
    mem[12'h208 >> 1] = 16'hAB12;
    mem[12'h20A >> 1] = 16'h3456;
    put_desc(32'h240, 'hA002, 32'h300);
    set_byte(32'h248, 8'h1F);
    for (int b = 1; b < 16; b++) set_byte(32'h248 + b, 8'(8'h20 + b));
    set_byte(32'h248 + 10, 8'h03);
    set_byte(32'h248 + 13, 8'h80);
    put_desc(32'h300, 'h0000, 32'h0);
    lat = 2;
    run("R8", 32'h200, 1'b0);

    // R6: odd count 9 ends on an all-ones link, byte 9 must stay
    put_desc(32'h400, 'h0002, 32'hFFFF_FFFF);
    set_byte(32'h408, 8'h09);
    for (int b = 1; b < 12; b++) set_byte(32'h408 + b, 8'(8'h60 + b));
    set_byte(32'h408 + 9, 8'hEE);
    lat = 1;
    run("R6", 32'h400, 1'b0);

    // R4 R9: external opcodes, last one suspends with end of list
    put_desc(32'h500, 'h0001, 32'h520);
    put_desc(32'h520, 'h0003, 32'h540);
    put_desc(32'h540, 'h0004, 32'h560);
    put_desc(32'h560, 'h0006, 32'h580);
    put_desc(32'h580, 'hC007, 32'h5A0);
    lat = 3;
    run("R9", 32'h500, 1'b0);

    // R11: null start from suspended goes idle with no access
    run("R11", 32'h0, 1'b0);

    // R5 R9 R11: link down, suspend wins over null link, start poked mid-walk
    link_up = 1'b0;
    put_desc(32'h600, 'h2005, 32'h640);
    put_desc(32'h640, 'h4000, 32'h0);
    lat = 2;
    run("R5", 32'h600, 1'b1);
    link_up = 1'b1;

    // R10 R11: restart from suspended, end of list with interrupt
    put_desc(32'h700, 'hA000, 32'h740);
    lat = 0;
    run("R10", 32'h700, 1'b0);

    report();
  end

endmodule